// File: doc/BRIEF.md
# Asynchronous 8N1 Serial Receiver with Framing Recovery

This block turns an asynchronous serial line into bytes. The line idles high. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. A fractional divider makes a sample tick at eight ticks per bit period. The divider is 16 integer bits and 8 fraction bits, counted in system clocks per tick. The serial input first passes through a two-flop synchronizer. On a tick where the synchronized line reads low, the receiver takes that as a start bit. It samples the first data bit twelve ticks later, which is about the middle of that bit. Each later data bit is sampled eight ticks after the one before it.

One bit period after the last data bit, the receiver reads the stop level. If the stop level is high, the byte goes to a holding register with a valid/ready handshake. The receiver then looks for the next start bit at once, so a transmitter running slightly fast still works. If the stop level is low, the receiver treats it as a framing error or a break. It drops the byte, sets a sticky error flag, and waits for the line to go high again before it looks for a new start bit. A byte that completes while the previous one has not been taken overwrites it and sets a sticky overrun flag. One clear input resets both flags.

Top module: `uart8_rx`

## Requirements
- R1: One sample tick occurs every div_setting/256 system clocks on average. div_setting[23:8] is the integer part and div_setting[7:0] is the fraction. An integer part of 0 behaves as 1, which gives one tick per clock.
- R2: The serial input is synchronized through two flops. While the line stays high, no byte is delivered and no flag is set.
- R3: The first data bit is sampled 12 ticks after the tick that saw the start bit, and each following bit 8 ticks after the one before it. The first bit received lands in out_data[0] and the eighth in out_data[7].
- R4: A frame with a high stop level raises out_valid with the byte on out_data. Both hold unchanged while out_valid is high and out_ready is low.
- R5: After a good stop level, the receiver looks for a start bit on the very next tick. A frame whose start bit directly follows the previous stop bit, with no idle time between them, is received correctly.
- R6: A frame with a low stop level sets frame_err and delivers no byte.
- R7: After a low stop level, the receiver ignores the line until it reads high. A long break yields exactly one error and no byte, and the first frame after the line returns high is received correctly.
- R8: frame_err stays set until err_clear is high in a cycle. If err_clear is high in the same cycle a new error is raised, the flag ends up set.
- R9: If a byte completes while out_valid is high and out_ready is low, the new byte replaces the old one on out_data and overrun is set. overrun stays set until err_clear.
- R10: After reset, out_valid, frame_err and overrun are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| div_setting | input | 24 | System clocks per sample tick, unsigned 16.8 fixed point |
| out_data | output | 8 | Last received byte |
| out_valid | output | 1 | out_data holds a byte not yet taken |
| out_ready | input | 1 | Consumer takes the byte when it is high together with out_valid |
| frame_err | output | 1 | Sticky flag for a bad stop level (framing error or break) |
| overrun | output | 1 | Sticky flag for a byte lost to overwrite |
| err_clear | input | 1 | Clears frame_err and overrun |

## Verification
The stop level is read about nine and a half bit periods after the falling edge of the start bit. Adding the two synchronizer flops, up to one tick of detection lag and one output register, the byte is due before the driven stop bit ends. Each expected byte is queued when its frame is driven. Once the full stop bit has been driven, the queue must be empty. The error and overrun flags are read at that same point, when the frame is done. The break and the continuous-clear cases instead watch every falling edge of the clock, because a flag that is cleared again at once is high for only one cycle. Frames are driven at the exact bit period for the divider under test: 4.0, 4.5 and 0.0 (treated as 1).

// File: rtl/uart8_rx_pkg.sv
package uart8_rx_pkg;

    localparam int DATA_BITS  = 8;
    localparam int OVS        = 8;   // ticks per bit
    localparam int FIRST_OFS  = 12;  // ticks from start detect to data bit 0
    localparam int DIV_INT_W  = 16;
    localparam int DIV_FRAC_W = 8;
    localparam int DIV_W      = DIV_INT_W + DIV_FRAC_W;
    localparam int CNT_W      = $clog2(FIRST_OFS);
    localparam int IDX_W      = $clog2(DATA_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_STOP,
        ST_WAIT_HIGH
    } rx_state_e;

    typedef struct packed {
        rx_state_e              state;
        logic [CNT_W-1:0]       cnt;
        logic [IDX_W-1:0]       idx;
        logic [DATA_BITS-1:0]   shreg;
    } rx_ctx_t;

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
        if (d[DIV_W-1:DIV_FRAC_W] == '0)
            return {{(DIV_INT_W-1){1'b0}}, 1'b1, d[DIV_FRAC_W-1:0]};
        return d;
    endfunction

endpackage

// File: rtl/rx_tick_gen.sv
module rx_tick_gen
    import uart8_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_setting,
    output logic             tick
);
    localparam int ACC_W = DIV_W + 1;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(1) << DIV_FRAC_W;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] acc_next;
    logic [ACC_W-1:0] div_ext;

    always_comb begin
        div_ext  = {1'b0, eff_div(div_setting)};
        acc_next = acc + STEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            tick <= 1'b0;
        end else if (acc_next >= div_ext) begin
            acc  <= acc_next - div_ext;
            tick <= 1'b1;
        end else begin
            acc  <= acc_next;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_sync.sv
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart8_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 line,
    output logic                 byte_done,
    output logic [DATA_BITS-1:0] byte_val,
    output logic                 err_pulse
);
    localparam logic [CNT_W-1:0] FIRST_LOAD = CNT_W'(FIRST_OFS - 1);
    localparam logic [CNT_W-1:0] BIT_LOAD   = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(DATA_BITS - 1);

    rx_ctx_t cur, nxt;

    always_comb begin
        nxt       = cur;
        byte_done = 1'b0;
        err_pulse = 1'b0;
        if (tick) begin
            unique case (cur.state)
                ST_IDLE: begin
                    if (!line) begin
                        nxt.state = ST_DATA;
                        nxt.cnt   = FIRST_LOAD;
                        nxt.idx   = '0;
                    end
                end
                ST_DATA: begin
                    if (cur.cnt == '0) begin
                        nxt.shreg = {line, cur.shreg[DATA_BITS-1:1]};
                        nxt.cnt   = BIT_LOAD;
                        if (cur.idx == LAST_IDX) nxt.state = ST_STOP;
                        else                     nxt.idx   = cur.idx + 1'b1;
                    end else begin
                        nxt.cnt = cur.cnt - 1'b1;
                    end
                end
                ST_STOP: begin
                    if (cur.cnt == '0) begin
                        if (line) begin
                            byte_done = 1'b1;
                            nxt.state = ST_IDLE;
                        end else begin
                            err_pulse = 1'b1;
                            nxt.state = ST_WAIT_HIGH;
                        end
                    end else begin
                        nxt.cnt = cur.cnt - 1'b1;
                    end
                end
                ST_WAIT_HIGH: begin
                    if (line) nxt.state = ST_IDLE;
                end
                default: nxt.state = ST_IDLE;
            endcase
        end
    end

    assign byte_val = cur.shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.state <= ST_IDLE;
            cur.cnt   <= '0;
            cur.idx   <= '0;
            cur.shreg <= '0;
        end else begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/rx_out_hold.sv
module rx_out_hold
    import uart8_rx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 byte_done,
    input  logic [DATA_BITS-1:0] byte_val,
    input  logic                 err_pulse,
    input  logic                 out_ready,
    input  logic                 err_clear,
    output logic [DATA_BITS-1:0] out_data,
    output logic                 out_valid,
    output logic                 frame_err,
    output logic                 overrun
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            frame_err <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            if (byte_done) begin
                out_data  <= byte_val;
                out_valid <= 1'b1;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end

            if (byte_done && out_valid && !out_ready) overrun <= 1'b1;
            else if (err_clear)                       overrun <= 1'b0;

            if (err_pulse)      frame_err <= 1'b1;
            else if (err_clear) frame_err <= 1'b0;
        end
    end
endmodule

// File: rtl/uart8_rx.sv
module uart8_rx
    import uart8_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_line,
    input  logic [23:0] div_setting,
    output logic [7:0]  out_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        frame_err,
    output logic        overrun,
    input  logic        err_clear
);
    logic                 tick;
    logic                 line_s;
    logic                 byte_done;
    logic                 err_pulse;
    logic [DATA_BITS-1:0] byte_val;

    rx_tick_gen u_tick (
        .clk(clk), .rst(rst), .div_setting(div_setting), .tick(tick)
    );

    rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(rx_line), .dout(line_s)
    );

    rx_frame_fsm u_fsm (
        .clk(clk), .rst(rst), .tick(tick), .line(line_s),
        .byte_done(byte_done), .byte_val(byte_val), .err_pulse(err_pulse)
    );

    rx_out_hold u_hold (
        .clk(clk), .rst(rst), .byte_done(byte_done), .byte_val(byte_val),
        .err_pulse(err_pulse), .out_ready(out_ready), .err_clear(err_clear),
        .out_data(out_data), .out_valid(out_valid), .frame_err(frame_err),
        .overrun(overrun)
    );
endmodule

// File: rtl/uart8_rx_chk.sv
module uart8_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] out_data,
    input logic       out_valid,
    input logic       out_ready,
    input logic       frame_err,
    input logic       overrun,
    input logic       err_clear,
    input logic       byte_done,
    input logic       err_pulse
);
    // R4: byte and valid hold while not taken and nothing new arrives
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !byte_done |=> out_valid && $stable(out_data));

    // R6: a frame ends either good or bad, never both
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(byte_done && err_pulse));

    // R6: a bad frame never raises valid
    a_r6_no_byte: assert property (@(posedge clk) disable iff (rst)
        err_pulse && !out_valid |=> !out_valid);

    // R8: sticky until clear; set wins over clear
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        frame_err && !err_clear |=> frame_err);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> frame_err);
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        err_clear && !err_pulse |=> !frame_err);

    // R9: overwrite of an untaken byte raises overrun
    a_r9_overrun: assert property (@(posedge clk) disable iff (rst)
        byte_done && out_valid && !out_ready |=> overrun);
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun && !err_clear |=> overrun);

    // R10: flags clear right after reset
    a_r10_reset: assert property (@(posedge clk)
        $past(rst) |-> !out_valid && !frame_err && !overrun);
endmodule

bind uart8_rx uart8_rx_chk u_chk (
    .clk(clk), .rst(rst), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .frame_err(frame_err), .overrun(overrun),
    .err_clear(err_clear), .byte_done(byte_done), .err_pulse(err_pulse)
);

// File: tb/uart8_rx_tb.sv
module uart8_rx_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_line = 1'b1;
    logic [23:0] div_setting = 24'h000400;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        frame_err;
    logic        overrun;
    logic        err_clear = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    int n_seen   = 0;
    bit mon_en   = 1'b1;
    bit err_seen = 1'b0;
    bit done     = 1'b0;
    logic [7:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart8_rx u_dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .div_setting(div_setting),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .frame_err(frame_err), .overrun(overrun), .err_clear(err_clear)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: pops expected bytes as the design hands them over
    always @(negedge clk) begin
        if (frame_err) err_seen = 1'b1;
        if (!rst && mon_en && out_valid && out_ready) begin
            n_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected byte", out_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(out_data == e, "R3/R4 byte value", out_data, e);
            end
        end
    end

    task automatic drive_bit(input logic b, input int cpb);
        rx_line = b;
        repeat (cpb) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic stop_lvl,
                        input int cpb, input bit expect_byte);
        if (expect_byte) exp_q.push_back(b);
        drive_bit(1'b0, cpb);
        for (int i = 0; i < 8; i++) drive_bit(b[i], cpb);
        drive_bit(stop_lvl, cpb);
        if (expect_byte)
            check(exp_q.size() == 0, "R4 byte due by end of stop bit", exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10
        check(!out_valid && !frame_err && !overrun, "R10 reset state",
              {out_valid, frame_err, overrun}, 0);
        // R2: idle line yields nothing
        repeat (400) @(negedge clk);
        check(n_seen == 0 && !frame_err, "R2 idle line quiet", n_seen, 0);

        // R3/R4 with div 4.0 -> 32 clocks per bit
        send(8'h55, 1'b1, 32, 1'b1); drive_bit(1'b1, 64);
        send(8'hA5, 1'b1, 32, 1'b1); drive_bit(1'b1, 64);
        send(8'h01, 1'b1, 32, 1'b1); drive_bit(1'b1, 64);
        send(8'h80, 1'b1, 32, 1'b1); drive_bit(1'b1, 64);
        send(8'h00, 1'b1, 32, 1'b1); drive_bit(1'b1, 64);
        send(8'hFF, 1'b1, 32, 1'b1); drive_bit(1'b1, 64);

        // R5: back-to-back frames, no idle gap
        send(8'h3C, 1'b1, 32, 1'b1);
        send(8'hC3, 1'b1, 32, 1'b1);
        send(8'h96, 1'b1, 32, 1'b1);
        drive_bit(1'b1, 64);
        check(n_seen == 9, "R5 back-to-back count", n_seen, 9);

        // R6: bad stop bit
        send(8'h5A, 1'b0, 32, 1'b0);
        drive_bit(1'b1, 64);
        check(frame_err == 1'b1, "R6 frame_err set", frame_err, 1);
        check(n_seen == 9, "R6 no byte delivered", n_seen, 9);
        // R8: stays set, then clears on pulse
        drive_bit(1'b1, 100);
        check(frame_err == 1'b1, "R8 sticky", frame_err, 1);
        err_clear = 1'b1; @(negedge clk); err_clear = 1'b0; @(negedge clk);
        check(frame_err == 1'b0, "R8 cleared by pulse", frame_err, 0);

        // R7: long break, then recovery
        err_seen = 1'b0;
        drive_bit(1'b0, 32 * 30);
        check(frame_err == 1'b1, "R7 break flagged", frame_err, 1);
        check(n_seen == 9, "R7 break delivers no byte", n_seen, 9);
        err_clear = 1'b1; @(negedge clk); err_clear = 1'b0;
        drive_bit(1'b0, 32 * 10);
        check(frame_err == 1'b0, "R7 single error during break", frame_err, 0);
        drive_bit(1'b1, 64);
        send(8'hE7, 1'b1, 32, 1'b1); drive_bit(1'b1, 64);
        check(n_seen == 10, "R7 recovers after break", n_seen, 10);

        // R8: set wins over clear held high
        err_seen = 1'b0;
        err_clear = 1'b1;
        send(8'h11, 1'b0, 32, 1'b0);
        drive_bit(1'b1, 64);
        check(err_seen == 1'b1, "R8 set wins over clear", err_seen, 1);
        check(frame_err == 1'b0, "R8 cleared while held", frame_err, 0);
        err_clear = 1'b0;

        // R9: overrun
        mon_en = 1'b0; out_ready = 1'b0;
        send(8'h12, 1'b1, 32, 1'b0); drive_bit(1'b1, 64);
        check(out_valid && out_data == 8'h12 && !overrun, "R4 held unread",
              out_data, 8'h12);
        send(8'h34, 1'b1, 32, 1'b0); drive_bit(1'b1, 64);
        check(out_data == 8'h34, "R9 overwrite data", out_data, 8'h34);
        check(overrun == 1'b1, "R9 overrun set", overrun, 1);
        out_ready = 1'b1; @(negedge clk); @(negedge clk);
        check(out_valid == 1'b0, "R4 taken on ready", out_valid, 0);
        check(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
        err_clear = 1'b1; @(negedge clk); err_clear = 1'b0; @(negedge clk);
        check(overrun == 1'b0, "R9 overrun cleared", overrun, 0);
        mon_en = 1'b1;

        // R1: fractional divider 4.5 -> 36 clocks per bit
        div_setting = 24'h000480;
        drive_bit(1'b1, 64);
        send(8'hB4, 1'b1, 36, 1'b1); drive_bit(1'b1, 72);
        send(8'h4B, 1'b1, 36, 1'b1); drive_bit(1'b1, 72);
        // R1: integer part 0 treated as 1 -> 8 clocks per bit
        div_setting = 24'h000000;
        drive_bit(1'b1, 32);
        send(8'hD2, 1'b1, 8, 1'b1); drive_bit(1'b1, 16);
        send(8'h2D, 1'b1, 8, 1'b1); drive_bit(1'b1, 16);
        check(n_seen == 14, "R1 divider variants count", n_seen, 14);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule